// File: doc/BRIEF.md
# Task Precedence Closure Engine

The engine keeps a square Boolean matrix that records which tasks in a small set must finish before others may start. Bit j of row i is 1 when task i must complete before task j can begin. When it is started, the engine raises the matrix to successive Boolean powers, using AND as the product and OR as the sum. It ORs each nonzero power into a result matrix and stops when a power becomes all zero. The result is the full implied precedence relation. One matrix product is formed per clock cycle by a combinational array of AND-OR trees.

When the engine is idle, it compares the result matrix with a vector of task-completion flags and reports which tasks may run now. If the powers are still nonzero after N products, the precedence graph contains a cycle. In that case the engine stops, flags an error and still signals completion. Rows are written through a load port. The result is read one row at a time through an address-selected read port.

Top module: `prec_closure_top`

## Requirements
- R1: A write on a clock edge with `ld_en` high and the engine idle stores `ld_data` as row `ld_row` of the direct matrix. Bit j of row i set means task i precedes task j.
- R2: After completion, row i read through `rd_row`/`rd_data` equals row i of the transitive closure of the direct matrix. This is the OR of all its nonzero Boolean powers.
- R3: For an acyclic matrix whose longest precedence chain has D edges, `done` rises on the (D+1)-th clock edge after the edge that accepts `start`. A zero matrix takes one edge.
- R4: When the N-th power is nonzero (a cycle exists), `cycle_err` and `done` are both set on the N-th edge after the accepting edge. For an acyclic matrix, `cycle_err` stays 0.
- R5: `done` and `cycle_err` hold their values until the next accepted `start`, which clears them on the same edge.
- R6: From the accepting edge until `done` rises, `ready` is all zeros.
- R7: While idle, `ready[j]` is 1 exactly when `cmpl[j]` is 0 and every task i with closure bit (i,j) set has `cmpl[i]` set. A task whose own flag is set is never ready.
- R8: A `start` pulse seen while the engine is busy has no effect on the running computation or its completion time.
- R9: Row writes presented while the engine is busy are discarded.
- R10: After reset, the closure matrix is all zero and `done` and `cycle_err` are 0, so every task whose flag is clear is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Row write enable |
| ld_row | input | IW | Row index to write |
| ld_data | input | N | Row contents (bit j: this task precedes task j) |
| start | input | 1 | Begin a closure computation |
| done | output | 1 | Computation finished; held until next start |
| cycle_err | output | 1 | Precedence cycle detected in last run |
| rd_row | input | IW | Closure row to read |
| rd_data | output | N | Selected closure row |
| cmpl | input | N | Task completion flags |
| ready | output | N | Tasks that may run now |

## Verification
The results depend on one registered stage. `done` and `cycle_err` change on the (D+1)-th edge after the accepting edge, or on the N-th edge when there is a cycle. The bench counts falling edges from the first one after the accepting edge and compares that count with a value it derives from a longest-path relaxation. `ready` and `rd_data` are combinational from the stored closure. The bench therefore drives `cmpl` or `rd_row` on a falling edge and samples half a period later. It sweeps all 256 completion patterns against a closure it computes by Warshall's method. Busy-time stimuli are injected at a known count inside the run, where they fall on edges that the run still covers.

// File: rtl/prec_pkg.sv
package prec_pkg;
   // width of an index over n items, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/prec_bool_matmul.sv
module prec_bool_matmul #(
   parameter int N = 8
) (
   input  logic [N-1:0][N-1:0] lhs,
   input  logic [N-1:0][N-1:0] rhs,
   output logic [N-1:0][N-1:0] prod
);
   // prod(i,j) = OR over k of lhs(i,k) AND rhs(k,j)
   for (genvar j = 0; j < N; j++) begin : g_col
      logic [N-1:0] col;
      for (genvar k = 0; k < N; k++) begin : g_pick
         assign col[k] = rhs[k][j];
      end
      for (genvar i = 0; i < N; i++) begin : g_row
         assign prod[i][j] = |(lhs[i] & col);
      end
   end
endmodule

// File: rtl/prec_ready_eval.sv
module prec_ready_eval #(
   parameter int N = 8
) (
   input  logic               en,
   input  logic [N-1:0][N-1:0] clo,
   input  logic [N-1:0]       cmpl,
   output logic [N-1:0]       ready
);
   for (genvar j = 0; j < N; j++) begin : g_task
      logic [N-1:0] preds;
      for (genvar i = 0; i < N; i++) begin : g_p
         assign preds[i] = clo[i][j];
      end
      // blocked when any predecessor is still incomplete
      assign ready[j] = en & ~cmpl[j] & ~|(preds & ~cmpl);
   end
endmodule

// File: rtl/prec_closure_ctrl.sv
module prec_closure_ctrl #(
   parameter int N = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [N-1:0][N-1:0] mat,
   input  logic [N-1:0][N-1:0] prod,
   output logic [N-1:0][N-1:0] power,
   output logic [N-1:0][N-1:0] clo,
   output logic               busy,
   output logic               done,
   output logic               cycle_err
);
   localparam int CW = prec_pkg::idx_w(N);
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   logic [CW-1:0] step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         cycle_err <= 1'b0;
         power     <= '0;
         clo       <= '0;
         step      <= '0;
      end else if (!busy) begin
         if (start) begin
            busy      <= 1'b1;
            done      <= 1'b0;
            cycle_err <= 1'b0;
            power     <= mat;
            clo       <= '0;
            step      <= '0;
         end
      end else if (power == '0) begin
         busy <= 1'b0;
         done <= 1'b1;
      end else begin
         clo   <= clo | power;
         power <= prod;
         step  <= step + 1'b1;
         if (step == LAST) begin
            // N-th power still nonzero: a precedence cycle exists
            busy      <= 1'b0;
            done      <= 1'b1;
            cycle_err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/prec_closure_top.sv
module prec_closure_top #(
   parameter int N  = 8,
   parameter int IW = prec_pkg::idx_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [IW-1:0] ld_row,
   input  logic [N-1:0]  ld_data,
   input  logic          start,
   output logic          done,
   output logic          cycle_err,
   input  logic [IW-1:0] rd_row,
   output logic [N-1:0]  rd_data,
   input  logic [N-1:0]  cmpl,
   output logic [N-1:0]  ready
);
   if (N < 2 || N > 64) begin : g_bad_n
      $error("prec_closure_top: N must lie in 2..64");
   end
   if (IW < prec_pkg::idx_w(N)) begin : g_bad_iw
      $error("prec_closure_top: IW too narrow for N");
   end

   logic [N-1:0][N-1:0] mat;
   logic [N-1:0][N-1:0] power;
   logic [N-1:0][N-1:0] prod;
   logic [N-1:0][N-1:0] clo;
   logic                busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mat <= '0;
      end else if (ld_en && !busy && (int'(ld_row) < N)) begin
         mat[ld_row] <= ld_data;
      end
   end

   prec_bool_matmul #(.N(N)) u_mul (
      .lhs  (power),
      .rhs  (mat),
      .prod (prod)
   );

   prec_closure_ctrl #(.N(N)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mat       (mat),
      .prod      (prod),
      .power     (power),
      .clo       (clo),
      .busy      (busy),
      .done      (done),
      .cycle_err (cycle_err)
   );

   prec_ready_eval #(.N(N)) u_rdy (
      .en    (~busy),
      .clo   (clo),
      .cmpl  (cmpl),
      .ready (ready)
   );

   always_comb begin
      rd_data = '0;
      if (int'(rd_row) < N) rd_data = clo[rd_row];
   end
endmodule

// File: rtl/prec_closure_chk.sv
module prec_closure_chk #(
   parameter int N = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic               cycle_err,
   input logic [N-1:0]       ready,
   input logic [N-1:0]       cmpl,
   input logic [N-1:0][N-1:0] mat
);
   localparam int BW = $clog2(N + 2) + 1;
   logic [BW-1:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) bcnt <= '0;
      else                 bcnt <= bcnt + 1'b1;
   end

   p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ready == '0));
   p_own_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready & cmpl) == '0);
   p_finish_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_err |-> done);
   p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < BW'(N)));
   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && !done && !cycle_err));
   p_mat_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mat));
endmodule

bind prec_closure_top prec_closure_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .cycle_err (cycle_err),
   .ready     (ready),
   .cmpl      (cmpl),
   .mat       (mat)
);

// File: tb/sim_prec_closure_top.sv
`timescale 1ns/1ps
module sim_prec_closure_top;
   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_en = 1'b0;
   logic [IW-1:0] ld_row = '0;
   logic [N-1:0]  ld_data = '0;
   logic          start = 1'b0;
   logic          done, cycle_err;
   logic [IW-1:0] rd_row = '0;
   logic [N-1:0]  rd_data;
   logic [N-1:0]  cmpl = '0;
   logic [N-1:0]  ready;

   int errors = 0;
   int checks = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   prec_closure_top #(.N(N)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row),
      .ld_data(ld_data), .start(start), .done(done), .cycle_err(cycle_err),
      .rd_row(rd_row), .rd_data(rd_data), .cmpl(cmpl), .ready(ready)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   function automatic logic [N-1:0][N-1:0] ref_closure(input logic [N-1:0][N-1:0] m);
      logic [N-1:0][N-1:0] c = m;
      for (int k = 0; k < N; k++)
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               if (c[i][k] && c[k][j]) c[i][j] = 1'b1;
      return c;
   endfunction

   function automatic int ref_latency(input logic [N-1:0][N-1:0] m);
      logic [N-1:0][N-1:0] c = ref_closure(m);
      int d [N];
      int mx = 0;
      for (int i = 0; i < N; i++) if (c[i][i]) return N;
      for (int i = 0; i < N; i++) d[i] = 0;
      for (int r = 0; r < N; r++)
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               if (m[i][j] && d[j] < d[i] + 1) d[j] = d[i] + 1;
      for (int i = 0; i < N; i++) if (d[i] > mx) mx = d[i];
      return mx + 1;
   endfunction

   task automatic load(input logic [N-1:0][N-1:0] m);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_row = IW'(i); ld_data = m[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic run_case(input logic [N-1:0][N-1:0] m, input bit disturb);
      logic [N-1:0][N-1:0] c = ref_closure(m);
      int lat = ref_latency(m);
      bit cyc = (lat == N) && (ref_closure(m)[0] !== 'x) && (|{c[0][0], c[1][1], c[2][2], c[3][3], c[4][4], c[5][5], c[6][6], c[7][7]});
      int cnt = 0;
      load(m);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // state after the accepting edge
      chk("R5 done cleared by start", 32'(done), 0);
      chk("R6 ready zero while busy", 32'(ready), 0);
      while (!done && cnt < 40) begin
         if (disturb && cnt == 2) begin
            start = 1'b1; ld_en = 1'b1; ld_row = '0; ld_data = ~m[0];
         end
         @(negedge clk);
         start = 1'b0; ld_en = 1'b0;
         cnt++;
         if (!done) chk("R6 ready zero while busy", 32'(ready), 0);
      end
      if (disturb) chk("R8 latency unchanged by start while busy", 32'(cnt), 32'(lat));
      else if (cyc) chk("R4 cycle latency", 32'(cnt), 32'(lat));
      else chk("R3 latency", 32'(cnt), 32'(lat));
      chk("R4 cycle_err", 32'(cycle_err), 32'(cyc));
      for (int i = 0; i < N; i++) begin
         @(negedge clk); rd_row = IW'(i);
         #5;
         if (disturb) chk("R9 closure row after discarded write", 32'(rd_data), 32'(c[i]));
         else chk("R2 closure row", 32'(rd_data), 32'(c[i]));
      end
      repeat (5) @(negedge clk);
      chk("R5 done held", 32'(done), 1);
      chk("R5 cycle_err held", 32'(cycle_err), 32'(cyc));
      for (int p = 0; p < (1 << N); p++) begin
         logic [N-1:0] exp;
         @(negedge clk); cmpl = N'(p);
         #5;
         for (int j = 0; j < N; j++) begin
            exp[j] = !cmpl[j];
            for (int i = 0; i < N; i++)
               if (c[i][j] && !cmpl[i]) exp[j] = 1'b0;
         end
         chk("R7 ready vector", 32'(ready), 32'(exp));
      end
      @(negedge clk); cmpl = '0;
   endtask

   logic [15:0] lfsr = 16'hACE1;
   function automatic bit rbit();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   initial begin
      logic [N-1:0][N-1:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      chk("R10 done after reset", 32'(done), 0);
      chk("R10 cycle_err after reset", 32'(cycle_err), 0);
      chk("R10 ready after reset", 32'(ready), 32'hFF);
      for (int i = 0; i < N; i++) begin
         @(negedge clk); rd_row = IW'(i); #5;
         chk("R10 closure zero after reset", 32'(rd_data), 0);
      end

      // zero matrix
      m = '0; run_case(m, 1'b0);
      // R1 chain 0->1->...->7 with busy-time disturbance
      m = '0; for (int i = 0; i < N - 1; i++) m[i][i+1] = 1'b1;
      run_case(m, 1'b1);
      // diamond 0->{1,2}->3, 3->5
      m = '0; m[0][1] = 1; m[0][2] = 1; m[1][3] = 1; m[2][3] = 1; m[3][5] = 1;
      run_case(m, 1'b0);
      // reversed chain
      m = '0; for (int i = 1; i < N; i++) m[i][i-1] = 1'b1;
      run_case(m, 1'b0);
      // random DAGs, forward and relabelled order
      for (int t = 0; t < 4; t++) begin
         m = '0;
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
               int a = (t[0]) ? (i ^ 5) : i;
               int b = (t[0]) ? (j ^ 5) : j;
               if (a < b && rbit() && (t < 2 || rbit())) m[i][j] = 1'b1;
            end
         run_case(m, 1'b0);
      end
      // ring: cycle through all tasks
      m = '0; for (int i = 0; i < N; i++) m[i][(i+1)%N] = 1'b1;
      run_case(m, 1'b0);
      // self-loop on task 3 plus a branch
      m = '0; m[3][3] = 1; m[1][3] = 1; m[3][6] = 1;
      run_case(m, 1'b0);
      // acyclic after a cycle clears the error
      m = '0; m[2][4] = 1;
      run_case(m, 1'b0);
      finish_run();
   end
endmodule